// File: doc/BRIEF.md
# OTN Path Monitor Overhead Inserter

This block builds the three-byte path monitor field that goes into every outgoing OTUk frame: a trail trace byte, a BIP-8 byte, and a status byte. The status byte carries a 4-bit backward error count, a backward defect bit and a 3-bit status code. A 2-bit source selector chooses where each subfield comes from. The choices are internal logic, an external side port, the received path monitor field, or a mix of internal and side-port values.

The BIP-8 is the even parity, taken bitwise, of every payload byte of a frame. The parity of frame i is inserted into frame i+2. Maintenance conditions replace the whole field with fixed patterns. A trail-level AIS replaces it with a PN-11 pseudo-random sequence. When updating is switched off, the field falls back to the side port, or to zero if the build has no side port.

The surrounding frame logic supplies a pulse on the first cycle of each frame, the multiframe counter, and a strobe for each payload byte. The new field appears on the cycle after the frame pulse and is held until the next pulse.

Top module: `pm_ovh_inserter`

## Requirements
- R1: After reset `pm_out` is zero and `pm_valid` is low. `pm_out` changes only on the cycle after a `frame_start` cycle, and `pm_valid` is high exactly on those cycles.
- R2: With `src_sel`=00 and no override, the field is {trace byte, internal BIP-8, `bei_in`, internal defect bit, status register}. The bit layout is [23:16] trace, [15:8] BIP-8, [7:4] BEI, [3] BDI, [2:0] STAT.
- R3: With `src_sel`=01, every subfield except BIP-8 comes from `side_pm`, using the same layout. BIP-8 is the internal value.
- R4: With `src_sel`=10, the field equals `rx_pm` unchanged, BIP-8 included.
- R5: With `src_sel`=11, the trace byte, BIP-8 and STAT are internal, and BEI and BDI come from `side_pm`[7:3].
- R6: The internal BIP-8 inserted in frame k is the XOR of all strobed payload bytes of frame k-2. A byte strobed on a `frame_start` cycle belongs to the new frame. The first two frames after reset carry zero.
- R7: In the internal source mode (00), BDI is `los` OR `lof`, sampled on the `frame_start` cycle.
- R8: The status register resets to 001 and takes `stat_wdata` on a `stat_wr` cycle. A write on a `frame_start` cycle affects only later frames.
- R9: Maintenance overrides replace the whole field. AIS gives FFFFFF, LCK gives 555555 and OCI gives 666666. When several are active, AIS wins over LCK, and LCK wins over OCI. The overrides apply whatever `upd_en` is.
- R10: With `upd_en` low and no override, the field is `side_pm` when the side port is built in (default). Without the side port it is zero.
- R11: A frame with `otu_ais` high carries the next 24 bits of a PN-11 sequence, first bit in bit 23. The sequence is x(n+11) = x(n) XOR x(n+2), and its first 11 bits after reset are ones. The sequence advances only in such frames, and this override wins over all others.
- R12: The internal trace byte is entry `mfas` mod 64 of a 64-byte trace store. The store is written through `trace_wr`/`trace_waddr`/`trace_wdata` and cleared to zero by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | First cycle of an outgoing frame |
| mfas | input | 8 | Multiframe counter for this frame |
| pay_valid | input | 1 | Payload byte strobe |
| pay_byte | input | 8 | Payload byte |
| src_sel | input | 2 | Subfield source selector |
| upd_en | input | 1 | Field update enable |
| odu_ais | input | 1 | Path AIS maintenance active |
| odu_lck | input | 1 | Path lock maintenance active |
| odu_oci | input | 1 | Open connection maintenance active |
| otu_ais | input | 1 | Trail AIS, PN-11 fill |
| los | input | 1 | Drop-path loss of signal |
| lof | input | 1 | Drop-path loss of frame |
| bei_in | input | 4 | Error count from the overhead monitor |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 3 | Status register write value |
| trace_wr | input | 1 | Trace store write strobe |
| trace_waddr | input | 6 | Trace store write index |
| trace_wdata | input | 8 | Trace store write byte |
| side_pm | input | 24 | Side-port field, same layout as output |
| rx_pm | input | 24 | Received path monitor field |
| pm_out | output | 24 | Generated path monitor field |
| pm_valid | output | 1 | New field presented this cycle |

## Verification
On every cycle the assertions check the output timing, the three maintenance patterns and their priority, pass-through of the received field, and side-port sourcing in mode 01. These are all relations that can be read from a single frame boundary. Other behaviour spans several frames or needs history. This covers the BIP-8 carried two frames forward, the PN-11 sequence continuing across frames, the status register reset value and its writes, and the trace store lookup. Only the bench's reference model can show these, by following payload parity, trace contents and the sequence state from reset onward.

// File: rtl/pm_ovh_pkg.sv
package pm_ovh_pkg;

   localparam int unsigned FIELD_W = 24;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned BEI_W   = 4;
   localparam int unsigned STAT_W  = 3;

   typedef enum logic [1:0] {
      SRC_INTERNAL = 2'b00,
      SRC_SIDE     = 2'b01,
      SRC_RX       = 2'b10,
      SRC_MIXED    = 2'b11
   } pm_src_e;

   typedef struct packed {
      logic [BYTE_W-1:0] tti;
      logic [BYTE_W-1:0] bip;
      logic [BEI_W-1:0]  bei;
      logic              bdi;
      logic [STAT_W-1:0] stat;
   } pm_field_t;

   localparam logic [FIELD_W-1:0] PAT_AIS = 24'hFFFFFF;
   localparam logic [FIELD_W-1:0] PAT_LCK = 24'h555555;
   localparam logic [FIELD_W-1:0] PAT_OCI = 24'h666666;

endpackage

// File: rtl/pm_trace_store.sv
module pm_trace_store #(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= '0;
         end
      end else if (wr_en) begin
         mem_q[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/pm_bip_pipe.sv
module pm_bip_pipe #(
   parameter int unsigned W   = 8,
   parameter int unsigned LAG = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frame_start,
   input  logic         byte_valid,
   input  logic [W-1:0] byte_in,
   output logic [W-1:0] bip_out
);

   if (LAG < 2) begin : g_bad_lag
      $error("pm_bip_pipe: LAG must be at least 2");
   end

   logic [W-1:0] acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (frame_start) begin
         acc_q <= byte_valid ? byte_in : '0;
      end else if (byte_valid) begin
         acc_q <= acc_q ^ byte_in;
      end
   end

   for (genvar j = 1; j < LAG; j++) begin : g_stage
      logic [W-1:0] q;
      logic [W-1:0] d;
      if (j == 1) begin : g_first
         assign d = acc_q;
      end else begin : g_next
         assign d = g_stage[j-1].q;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (frame_start) begin
            q <= d;
         end
      end
   end

   assign bip_out = g_stage[LAG-1].q;

endmodule

// File: rtl/pm_pn11_gen.sv
module pm_pn11_gen #(
   parameter int unsigned BITS = 24
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   output logic [BITS-1:0] bits_o
);

   localparam int unsigned SW = 11;

   logic [SW-1:0] state_q;
   logic [SW-1:0] state_d;

   always_comb begin
      logic [SW-1:0] s;
      s = state_q;
      bits_o = '0;
      for (int i = 0; i < BITS; i++) begin
         bits_o[BITS-1-i] = s[SW-1];
         s = {s[SW-2:0], s[SW-1] ^ s[SW-3]};
      end
      state_d = s;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= '1;
      end else if (step) begin
         state_q <= state_d;
      end
   end

endmodule

// File: rtl/pm_ovh_inserter.sv
module pm_ovh_inserter
   import pm_ovh_pkg::*;
#(
   parameter int unsigned TTI_DEPTH     = 64,
   parameter int unsigned MFAS_W        = 8,
   parameter int unsigned BIP_LAG       = 2,
   parameter bit          HAS_SIDE_PORT = 1'b1,
   parameter logic [2:0]  STAT_RST      = 3'b001
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         frame_start,
   input  logic [MFAS_W-1:0]            mfas,
   input  logic                         pay_valid,
   input  logic [7:0]                   pay_byte,
   input  logic [1:0]                   src_sel,
   input  logic                         upd_en,
   input  logic                         odu_ais,
   input  logic                         odu_lck,
   input  logic                         odu_oci,
   input  logic                         otu_ais,
   input  logic                         los,
   input  logic                         lof,
   input  logic [3:0]                   bei_in,
   input  logic                         stat_wr,
   input  logic [2:0]                   stat_wdata,
   input  logic                         trace_wr,
   input  logic [$clog2(TTI_DEPTH)-1:0] trace_waddr,
   input  logic [7:0]                   trace_wdata,
   input  logic [23:0]                  side_pm,
   input  logic [23:0]                  rx_pm,
   output logic [23:0]                  pm_out,
   output logic                         pm_valid
);

   localparam int unsigned TAW = $clog2(TTI_DEPTH);

   if (TTI_DEPTH != (1 << TAW)) begin : g_bad_depth
      $error("pm_ovh_inserter: TTI_DEPTH must be a power of two");
   end
   if (MFAS_W < TAW) begin : g_bad_mfas
      $error("pm_ovh_inserter: MFAS_W narrower than trace index");
   end

   logic [BYTE_W-1:0]  trace_rd;
   logic [BYTE_W-1:0]  bip_ins;
   logic [FIELD_W-1:0] pn_bits;
   logic [STAT_W-1:0]  stat_q;
   logic [FIELD_W-1:0] idle_field;

   pm_trace_store #(
      .DEPTH  (TTI_DEPTH),
      .DATA_W (BYTE_W)
   ) u_trace (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (trace_wr),
      .wr_addr (trace_waddr),
      .wr_data (trace_wdata),
      .rd_addr (mfas[TAW-1:0]),
      .rd_data (trace_rd)
   );

   pm_bip_pipe #(
      .W   (BYTE_W),
      .LAG (BIP_LAG)
   ) u_bip (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .byte_valid  (pay_valid),
      .byte_in     (pay_byte),
      .bip_out     (bip_ins)
   );

   pm_pn11_gen #(
      .BITS (FIELD_W)
   ) u_pn (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (frame_start & otu_ais),
      .bits_o (pn_bits)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= STAT_RST;
      end else if (stat_wr) begin
         stat_q <= stat_wdata;
      end
   end

   if (HAS_SIDE_PORT) begin : g_idle_side
      assign idle_field = side_pm;
   end else begin : g_idle_zero
      assign idle_field = '0;
   end

   pm_field_t side_f;
   pm_field_t intl_f;
   pm_field_t next_f;

   always_comb begin
      side_f = pm_field_t'(side_pm);
      intl_f.tti  = trace_rd;
      intl_f.bip  = bip_ins;
      intl_f.bei  = bei_in;
      intl_f.bdi  = los | lof;
      intl_f.stat = stat_q;

      unique case (pm_src_e'(src_sel))
         SRC_INTERNAL: next_f = intl_f;
         SRC_SIDE: begin
            next_f     = side_f;
            next_f.bip = bip_ins;
         end
         SRC_RX:       next_f = pm_field_t'(rx_pm);
         SRC_MIXED: begin
            next_f     = intl_f;
            next_f.bei = side_f.bei;
            next_f.bdi = side_f.bdi;
         end
         default:      next_f = intl_f;
      endcase

      if (!upd_en)  next_f = pm_field_t'(idle_field);
      if (odu_oci)  next_f = pm_field_t'(PAT_OCI);
      if (odu_lck)  next_f = pm_field_t'(PAT_LCK);
      if (odu_ais)  next_f = pm_field_t'(PAT_AIS);
      if (otu_ais)  next_f = pm_field_t'(pn_bits);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pm_out   <= '0;
         pm_valid <= 1'b0;
      end else begin
         pm_valid <= frame_start;
         if (frame_start) begin
            pm_out <= next_f;
         end
      end
   end

endmodule

module pm_ovh_inserter_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        frame_start,
   input logic [1:0]  src_sel,
   input logic        upd_en,
   input logic        odu_ais,
   input logic        odu_lck,
   input logic        odu_oci,
   input logic        otu_ais,
   input logic [23:0] side_pm,
   input logic [23:0] rx_pm,
   input logic [23:0] pm_out,
   input logic        pm_valid
);

   logic no_ovr;
   assign no_ovr = !odu_ais && !odu_lck && !odu_oci && !otu_ais;

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pm_valid == $past(frame_start));

   assert_hold_between_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(pm_out));

   assert_ais_pattern_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && odu_ais && !otu_ais) |=> pm_out == 24'hFFFFFF);

   assert_lck_pattern_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && odu_lck && !odu_ais && !otu_ais) |=> pm_out == 24'h555555);

   assert_oci_pattern_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && odu_oci && !odu_lck && !odu_ais && !otu_ais)
         |=> pm_out == 24'h666666);

   assert_rx_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && upd_en && no_ovr && src_sel == 2'b10) |=> pm_out == $past(rx_pm));

   assert_side_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && upd_en && no_ovr && src_sel == 2'b01)
         |=> (pm_out[23:16] == $past(side_pm[23:16]) && pm_out[7:0] == $past(side_pm[7:0])));

endmodule

bind pm_ovh_inserter pm_ovh_inserter_chk u_chk (.*);

// File: tb/pm_ovh_inserter_bench.sv
module pm_ovh_inserter_bench;

   localparam int FLEN = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic [7:0]  mfas = '0;
   logic        pay_valid = 1'b0;
   logic [7:0]  pay_byte = '0;
   logic [1:0]  src_sel = '0;
   logic        upd_en = 1'b1;
   logic        odu_ais = 1'b0, odu_lck = 1'b0, odu_oci = 1'b0, otu_ais = 1'b0;
   logic        los = 1'b0, lof = 1'b0;
   logic [3:0]  bei_in = '0;
   logic        stat_wr = 1'b0;
   logic [2:0]  stat_wdata = '0;
   logic        trace_wr = 1'b0;
   logic [5:0]  trace_waddr = '0;
   logic [7:0]  trace_wdata = '0;
   logic [23:0] side_pm = '0, rx_pm = '0;
   logic [23:0] pm_out;
   logic        pm_valid;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   pm_ovh_inserter u_pm_ovh_inserter (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mfas(mfas),
      .pay_valid(pay_valid), .pay_byte(pay_byte), .src_sel(src_sel), .upd_en(upd_en),
      .odu_ais(odu_ais), .odu_lck(odu_lck), .odu_oci(odu_oci), .otu_ais(otu_ais),
      .los(los), .lof(lof), .bei_in(bei_in), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
      .trace_wr(trace_wr), .trace_waddr(trace_waddr), .trace_wdata(trace_wdata),
      .side_pm(side_pm), .rx_pm(rx_pm), .pm_out(pm_out), .pm_valid(pm_valid)
   );

   // Behavioural reference model
   logic [7:0]  m_trace [64];
   logic [7:0]  m_acc;
   logic [7:0]  m_bip_hist [$];
   bit          m_pn [$];
   logic [2:0]  m_stat;
   logic [23:0] exp_pm;
   logic        exp_valid;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_trace[i]) m_trace[i] = 8'h00;
         m_acc = 8'h00;
         m_bip_hist = {8'h00};
         m_pn = {};
         for (int i = 0; i < 11; i++) m_pn.push_back(1'b1);
         m_stat = 3'b001;
         exp_pm = '0;
         exp_valid = 1'b0;
      end else begin
         exp_valid = frame_start;
         if (frame_start) begin
            logic [7:0] bip;
            logic [23:0] f;
            m_bip_hist.push_back(m_acc);
            bip = m_bip_hist.pop_front();
            m_acc = pay_valid ? pay_byte : 8'h00;
            if (src_sel == 2'b00)      f = {m_trace[mfas % 64], bip, bei_in, los | lof, m_stat};
            else if (src_sel == 2'b01) f = {side_pm[23:16], bip, side_pm[7:0]};
            else if (src_sel == 2'b10) f = rx_pm;
            else                       f = {m_trace[mfas % 64], bip, side_pm[7:3], m_stat};
            if (!upd_en) f = side_pm;
            if (odu_ais)      f = 24'hFFFFFF;
            else if (odu_lck) f = 24'h555555;
            else if (odu_oci) f = 24'h666666;
            if (otu_ais) begin
               for (int k = 23; k >= 0; k--) begin
                  bit b;
                  b = m_pn.pop_front();
                  m_pn.push_back(b ^ m_pn[1]);
                  f[k] = b;
               end
            end
            exp_pm = f;
         end else if (pay_valid) begin
            m_acc = m_acc ^ pay_byte;
         end
         if (stat_wr)  m_stat = stat_wdata;
         if (trace_wr) m_trace[trace_waddr] = trace_wdata;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         checks++;
         if (pm_out !== exp_pm || pm_valid !== exp_valid) begin
            errors++;
            $display("FAIL %s: pm_out=%h valid=%b expected pm_out=%h valid=%b",
                     cur_req, pm_out, pm_valid, exp_pm, exp_valid);
         end
      end
   end

   task automatic run_frames(input int n);
      for (int f = 0; f < n; f++) begin
         for (int c = 0; c < FLEN; c++) begin
            @(negedge clk);
            frame_start = (c == 0);
            if (c == 0) mfas = mfas + 8'd1;
            pay_valid = (c < 8) && ($urandom_range(0, 3) != 0);
            pay_byte = 8'($urandom);
         end
      end
      @(negedge clk);
      frame_start = 1'b0;
      pay_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      checks++;
      if (pm_out !== 24'h0 || pm_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1: pm_out=%h valid=%b expected pm_out=000000 valid=0", pm_out, pm_valid);
      end
      // R12: fill trace store
      cur_req = "R12";
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         trace_wr = 1'b1;
         trace_waddr = 6'(i);
         trace_wdata = 8'((i * 37 + 11) & 255);
      end
      @(negedge clk);
      trace_wr = 1'b0;
      // R2 R6 R12: internal sources with payload parity
      cur_req = "R2/R6";
      bei_in = 4'hA;
      run_frames(6);
      // R7: defect bit from los/lof
      cur_req = "R7";
      los = 1'b1; run_frames(2);
      los = 1'b0; lof = 1'b1; run_frames(2);
      los = 1'b1; run_frames(1);
      los = 1'b0; lof = 1'b0; run_frames(1);
      // R8: status register write, including on a frame_start cycle
      cur_req = "R8";
      @(negedge clk);
      stat_wr = 1'b1; stat_wdata = 3'b110;
      @(negedge clk);
      stat_wr = 1'b0;
      run_frames(2);
      @(negedge clk);
      frame_start = 1'b1; stat_wr = 1'b1; stat_wdata = 3'b011;
      @(negedge clk);
      frame_start = 1'b0; stat_wr = 1'b0;
      run_frames(2);
      // R3: side port sources
      cur_req = "R3";
      src_sel = 2'b01; side_pm = 24'hC3_5A_9E; run_frames(2);
      side_pm = 24'h17_E2_41; run_frames(2);
      // R4: pass-through
      cur_req = "R4";
      src_sel = 2'b10; rx_pm = 24'hAB_CD_EF; run_frames(2);
      rx_pm = 24'h01_02_03; run_frames(1);
      // R5: mixed
      cur_req = "R5";
      src_sel = 2'b11; side_pm = 24'h00_00_F8; los = 1'b1; run_frames(2);
      side_pm = 24'hFF_FF_37; los = 1'b0; run_frames(2);
      // R9: maintenance patterns and priority
      cur_req = "R9";
      src_sel = 2'b00;
      odu_oci = 1'b1; run_frames(2);
      odu_lck = 1'b1; run_frames(2);
      odu_ais = 1'b1; run_frames(2);
      upd_en = 1'b0; run_frames(1);
      odu_ais = 1'b0; odu_lck = 1'b0; odu_oci = 1'b0; upd_en = 1'b1;
      // R10: update disabled
      cur_req = "R10";
      upd_en = 1'b0; side_pm = 24'h5E_A1_0C; run_frames(2);
      upd_en = 1'b1; run_frames(1);
      // R11: PN-11 fill, highest priority, advances only when active
      cur_req = "R11";
      otu_ais = 1'b1; run_frames(3);
      odu_ais = 1'b1; run_frames(1);
      otu_ais = 1'b0; odu_ais = 1'b0; run_frames(2);
      otu_ais = 1'b1; run_frames(2);
      otu_ais = 1'b0;
      // R6 R12: longer run wrapping the multiframe counter
      cur_req = "R6/R12";
      run_frames(70);
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule